// File: doc/BRIEF.md
# Pseudo-Static RAM Mode Controller

This block models the control side of a sixteen-bit pseudo-static RAM with a small storage array whose depth is set by a parameter. A sampling clock captures six asynchronous active-level strobes: a low-true chip select, a high-true power-keep select, write enable, output enable, and two low-true byte-lane enables. The block decodes these strobes into reads, byte-masked writes and deselects. It tracks a power mode and drives a separate output-enable bit for each byte lane of a bidirectional data bus.

Pulling the power-keep select low moves the block into deep power down. In that mode every stored byte is discarded. When power is applied, and again when the power-keep select returns high, a settling wait follows. A cycle counter times this wait from a clock-frequency parameter and a wait time in microseconds. Until the wait ends the block refuses every access and raises a one-cycle error flag for each sampled access attempt.

Strobes, address and write data are captured on one clock edge. Mode, ready, error and data outputs reflect that sample after the following edge. A write lands in storage on the same edge.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and just after it is released, mode is 0 (wait), ready is 0, dq_oe is 00 and err is 0.
- R2: Mode codes are 0 wait, 1 standby, 2 active and 3 deep power down. After reset release, ready stays low for WAIT_CYCLES = CLK_MHZ*WAIT_US clocks and then goes high, with mode 1 or 2.
- R3: A low power-keep select (cs2) forces mode 3 no matter what the other strobes do. The mode stays 3 for as long as cs2 is sampled low.
- R4: When cs2 is sampled high in mode 3, the mode goes to 0. The full WAIT_CYCLES wait then runs again before ready rises.
- R5: A byte lane that has not been written since reset or since the last deep power down reads as 0x00. This applies even if the lane held data before the deep power down.
- R6: With cs2 high and ready, the block is deselected when cs1_n is high or when lb_n and ub_n are both high. The mode is then 1 and dq_oe is 00.
- R7: A write happens when cs1_n, we_n and at least one lane enable are low. Only enabled lanes are stored: lb_n controls bits 7:0 and ub_n controls bits 15:8.
- R8: A read (selected, we_n high, oe_n low) sets dq_oe bit 0 to !lb_n and bit 1 to !ub_n. Each enabled lane of dq_out carries the stored byte, and each disabled lane carries 0x00.
- R9: When selected with we_n high and oe_n high, the mode is 2 (active) and dq_oe is 00.
- R10: While we_n is sampled low, dq_oe stays 00 whatever oe_n is.
- R11: An access sampled while the block is not ready (mode 0 or 3, or cs2 low) changes no stored data, and dq_oe stays 00.
- R12: err is high for one cycle for each sample in which cs1_n is low and a lane enable is low while the block is not ready or cs2 is low. Otherwise err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; its release marks the point where power is applied |
| cs1_n | input | 1 | Low-true chip select |
| cs2 | input | 1 | High-true power-keep select; low requests deep power down |
| we_n | input | 1 | Low-true write enable |
| oe_n | input | 1 | Low-true output enable |
| lb_n | input | 1 | Low-true enable for lane bits 7:0 |
| ub_n | input | 1 | Low-true enable for lane bits 15:8 |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus; disabled lanes are 0 |
| dq_oe | output | 2 | Per-lane output drive enable (bit 0 low lane, bit 1 high lane) |
| ready | output | 1 | High when accesses are accepted |
| mode | output | 2 | Power mode code |
| err | output | 1 | Pulses for one cycle per access attempted while not ready |

## Verification
The assertions assume that the strobes are stable relative to the sampling clock, so the captured value of each strobe is a clean level. They also assume that rst_n is released only when the power-keep select is high. The bench changes strobes only on falling clock edges and holds each pattern for at least two rising edges. It releases reset with cs2 high and returns cs2 high only after the other strobes are back at their idle levels.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,
        MODE_STBY = 2'd1,
        MODE_ACT  = 2'd2,
        MODE_DPD  = 2'd3
    } pmode_e;

    typedef struct packed {
        logic             cs1_n;
        logic             cs2;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] ben_n;   // bit 0 low lane, bit 1 high lane
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs1_n: 1'b1, cs2: 1'b1, we_n: 1'b1,
                                        oe_n: 1'b1, ben_n: {LANES{1'b1}}};

endpackage

// File: rtl/psram_strobe_sampler.sv
module psram_strobe_sampler
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           stb_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DATA_W-1:0] din_raw,
    output strobe_t           stb_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);

    typedef struct packed {
        strobe_t           stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.stb  = stb_raw;
        s_d.addr = addr_raw;
        s_d.din  = din_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stb  <= STROBE_IDLE;
            s_q.addr <= '0;
            s_q.din  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stb_q  = s_q.stb;
    assign addr_q = s_q.addr;
    assign din_q  = s_q.din;

endmodule

// File: rtl/psram_power_fsm.sv
module psram_power_fsm
    import psram_pkg::*;
#(
    parameter int WAIT_CYCLES = 50000,
    parameter int CNT_W       = $clog2(WAIT_CYCLES + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t stb,
    output pmode_e  mode_q,
    output logic    ready
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        pmode_e           mode;
        logic [CNT_W-1:0] cnt;
    } pwr_t;

    pwr_t p_d, p_q;
    logic sel;

    always_comb begin
        p_d = p_q;
        sel = !stb.cs1_n && !(&stb.ben_n);
        if (!stb.cs2) begin
            p_d.mode = MODE_DPD;
            p_d.cnt  = '0;
        end else begin
            case (p_q.mode)
                MODE_DPD: begin
                    p_d.mode = MODE_WAIT;
                    p_d.cnt  = RELOAD;
                end
                MODE_WAIT: begin
                    if (p_q.cnt == '0) begin
                        p_d.mode = sel ? MODE_ACT : MODE_STBY;
                    end else begin
                        p_d.cnt = p_q.cnt - 1'b1;
                    end
                end
                default: p_d.mode = sel ? MODE_ACT : MODE_STBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.mode <= MODE_WAIT;
            p_q.cnt  <= RELOAD;
        end else begin
            p_q <= p_d;
        end
    end

    assign mode_q = p_q.mode;
    assign ready  = (p_q.mode == MODE_STBY) || (p_q.mode == MODE_ACT);

    // R3
    dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.cs2 |=> (mode_q == MODE_DPD));

    // R4
    dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_DPD && mode_q != MODE_DPD) |-> (mode_q == MODE_WAIT));

    // R2
    wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_WAIT && ready) |-> ($past(p_q.cnt) == '0));

endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0][LANES-1:0]  vld;
    } arr_t;

    arr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (clear) begin
            a_d.vld = '0;
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lane[l]) begin
                    a_d.mem[addr][l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
                    a_d.vld[addr][l]                  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_data[g*LANE_W +: LANE_W] =
            a_q.vld[addr][g] ? a_q.mem[addr][g*LANE_W +: LANE_W] : '0;
    end

    // R5
    cleared_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (rd_data == '0));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ADDR_W  = $clog2(DEPTH),
    parameter int CLK_MHZ = 250,
    parameter int WAIT_US = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              ready,
    output logic [1:0]        mode,
    output logic              err
);

    localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;

    strobe_t           stb_raw, stb;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s, rd_data;
    pmode_e            mode_s;
    logic              rdy_s;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [LANES-1:0]  oe;
        logic              err;
    } out_t;

    out_t o_d, o_q;
    logic             sel, go, wr_en, rd_en;
    logic [LANES-1:0] lane_on;

    assign stb_raw = '{cs1_n: cs1_n, cs2: cs2, we_n: we_n, oe_n: oe_n, ben_n: {ub_n, lb_n}};

    psram_strobe_sampler #(.ADDR_W(ADDR_W)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_raw  (stb_raw),
        .addr_raw (addr),
        .din_raw  (dq_in),
        .stb_q    (stb),
        .addr_q   (addr_s),
        .din_q    (din_s)
    );

    psram_power_fsm #(.WAIT_CYCLES(WAIT_CYCLES)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .mode_q (mode_s),
        .ready  (rdy_s)
    );

    psram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (mode_s == MODE_DPD),
        .wr_en   (wr_en),
        .wr_lane (lane_on),
        .addr    (addr_s),
        .wr_data (din_s),
        .rd_data (rd_data)
    );

    always_comb begin
        o_d     = o_q;
        lane_on = ~stb.ben_n;
        sel     = !stb.cs1_n && (|lane_on);
        go      = rdy_s && stb.cs2 && sel;
        wr_en   = go && !stb.we_n;
        rd_en   = go && stb.we_n && !stb.oe_n;
        o_d.oe  = rd_en ? lane_on : '0;
        for (int l = 0; l < LANES; l++) begin
            o_d.dout[l*LANE_W +: LANE_W] =
                (rd_en && lane_on[l]) ? rd_data[l*LANE_W +: LANE_W] : '0;
        end
        o_d.err = sel && (!rdy_s || !stb.cs2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dq_out = o_q.dout;
    assign dq_oe  = o_q.oe;
    assign err    = o_q.err;
    assign ready  = rdy_s;
    assign mode   = mode_s;

    // R10
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dq_oe) |-> $past(stb.we_n));

    // R8
    low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[0] |-> !$past(stb.ben_n[0]));

    // R11
    drive_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dq_oe) |-> ready);

    // R12
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (dq_oe == '0));

endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;

    localparam int W = 500;   // CLK_MHZ 250 * WAIT_US 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs1_n = 1'b1, cs2 = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        ready, err;
    logic [1:0]  mode;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psram_ctrl #(.DEPTH(16), .CLK_MHZ(250), .WAIT_US(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ready(ready), .mode(mode), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cs1_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        settle();
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d, input logic l_n, input logic u_n);
        cs1_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; lb_n = l_n; ub_n = u_n; addr = a; dq_in = d;
        settle();
        idle();
    endtask

    task automatic do_read(input logic [3:0] a, input logic l_n, input logic u_n,
                           output logic [15:0] d, output logic [1:0] oe);
        cs1_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = l_n; ub_n = u_n; addr = a;
        settle();
        d = dq_out; oe = dq_oe;
        idle();
    endtask

    task automatic t_power_on();
        logic [15:0] d; logic [1:0] oe; int t0;
        check("R1 mode in reset", mode, 0);
        check("R1 ready in reset", ready, 0);
        @(negedge clk); rst_n = 1'b1; t0 = cyc;
        repeat (3) @(negedge clk);
        check("R1 mode after release", mode, 0);
        check("R1 dq_oe after release", dq_oe, 0);
        check("R1 err after release", err, 0);
        // R11 R12: write attempt during the wait
        cs1_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = 4'd3; dq_in = 16'hDEAD;
        settle();
        check("R12 err during wait", err, 1);
        check("R11 dq_oe during wait", dq_oe, 0);
        idle();
        check("R12 err clears", err, 0);
        wait_until(t0 + W - 2);
        check("R2 ready low before wait ends", ready, 0);
        wait_until(t0 + W + 2);
        check("R2 ready high after wait", ready, 1);
        check("R2 standby code", mode, 1);
        do_read(4'd3, 1'b0, 1'b0, d, oe);
        check("R11 ignored write left lane empty", d, 16'h0000);
        check("R8 read enables", oe, 2'b11);
    endtask

    task automatic t_masked();
        logic [15:0] d; logic [1:0] oe;
        do_write(4'd5, 16'hA1B2, 1'b0, 1'b0);
        do_read(4'd5, 1'b0, 1'b0, d, oe);
        check("R8 full word", d, 16'hA1B2);
        check("R8 both lanes on", oe, 2'b11);
        do_write(4'd5, 16'hFFFF, 1'b0, 1'b1);
        do_read(4'd5, 1'b0, 1'b0, d, oe);
        check("R7 low lane only written", d, 16'hA1FF);
        do_read(4'd5, 1'b0, 1'b1, d, oe);
        check("R8 low lane read data", d, 16'h00FF);
        check("R8 low lane enable", oe, 2'b01);
        do_read(4'd5, 1'b1, 1'b0, d, oe);
        check("R8 high lane read data", d, 16'hA100);
        check("R8 high lane enable", oe, 2'b10);
        do_write(4'd7, 16'h5566, 1'b1, 1'b0);
        do_read(4'd7, 1'b0, 1'b0, d, oe);
        check("R7 R5 high lane written, low lane empty", d, 16'h5500);
    endtask

    task automatic t_deselect();
        cs1_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        settle();
        check("R6 cs1 high mode", mode, 1);
        check("R6 cs1 high dq_oe", dq_oe, 0);
        cs1_n = 1'b0; lb_n = 1'b1; ub_n = 1'b1;
        settle();
        check("R6 no lanes mode", mode, 1);
        check("R6 no lanes dq_oe", dq_oe, 0);
        idle();
    endtask

    task automatic t_out_disable();
        cs1_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b1;
        settle();
        check("R9 active code", mode, 2);
        check("R9 outputs off", dq_oe, 0);
        idle();
    endtask

    task automatic t_write_hiz();
        cs1_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        addr = 4'd2; dq_in = 16'h0F0F;
        settle();
        for (int i = 0; i < 4; i++) begin
            check("R10 dq_oe during write", dq_oe, 0);
            @(negedge clk);
        end
        check("R10 active during write", mode, 2);
        idle();
    endtask

    task automatic t_dpd();
        logic [15:0] d; logic [1:0] oe; int t1;
        do_write(4'd9, 16'h1234, 1'b0, 1'b0);
        cs1_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = 4'd9;
        cs2 = 1'b0;
        settle();
        check("R3 deep power down code", mode, 3);
        check("R11 no drive in deep power down", dq_oe, 0);
        check("R12 err in deep power down", err, 1);
        repeat (8) @(negedge clk);
        check("R3 mode held", mode, 3);
        we_n = 1'b0; dq_in = 16'hBEEF;
        settle();
        check("R3 mode held under write strobes", mode, 3);
        cs1_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        settle();
        check("R12 err low without access", err, 0);
        cs2 = 1'b1; t1 = cyc;
        settle();
        check("R4 wait code after exit", mode, 0);
        wait_until(t1 + W - 1);
        check("R4 ready low during exit wait", ready, 0);
        wait_until(t1 + W + 4);
        check("R4 ready after exit wait", ready, 1);
        do_read(4'd9, 1'b0, 1'b0, d, oe);
        check("R5 data lost at addr 9", d, 16'h0000);
        do_read(4'd5, 1'b0, 1'b0, d, oe);
        check("R5 data lost at addr 5", d, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("[TB] FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_power_on();
        t_masked();
        t_deselect();
        t_out_disable();
        t_write_hiz();
        t_dpd();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule